// File: doc/BRIEF.md
# Windowed Interrupt Redirection Register File

This block is the register side of an I/O interrupt controller. Software sees only two 32-bit locations: an index port at byte offset 0x00 and a data port at byte offset 0x10. It writes a register number to the index port. A read or write at the data port then reaches the register that the index selects. Behind the window sit four things: an identification register, a version and capacity register, a boot delivery register, and a table of 64-bit redirection entries. Each entry is split into a low word and a high word.

Every redirection entry also drives a decoded routing record as plain outputs: mask, trigger mode, polarity, destination mode, delivery mode and destination ID. The logic that samples pins and sends messages uses these outputs. The table depth is a parameter. The advertised maximum entry index can be written exactly once, so firmware can lock the entry count. After that, entries above the locked index are closed to the window.

Top module: `irq_redir_regs`

## Requirements
- R1: A write at byte offset 0x00 loads the 8-bit index from bus_wdata[7:0]. A read at offset 0x00 returns the index in bits 7:0, with all other bits zero. The index resets to 0.
- R2: Register 0x00 stores the controller ID in bits 27:24. A data-port write changes only those bits, and every other bit of register 0x00 reads as 0. The ID resets to 0.
- R3: Register 0x01 reads the VERSION parameter in bits 7:0 and the maximum entry index in bits 23:16. All other bits read as 0. The maximum entry index resets to NUM_ENT-1.
- R4: The maximum entry index field is write-once. The first data-port write to register 0x01 loads bits 23:16, and every later write leaves the field unchanged. No write ever changes the version bits.
- R5: Register 0x03 stores bit 0, where 1 selects system-bus delivery and 0 selects the serial interrupt bus. Bits 31:1 read as 0, and the register resets to 0.
- R6: Entry n has its low word at register 0x10+2n and its high word at register 0x11+2n. A written word reads back unchanged at the same register number.
- R7: After reset, every entry's low word is 0x0001_0000 (masked) and every high word is 0, so every out_mask bit is 1.
- R8: Entry n drives its routing outputs from its stored words, one cycle after a write. The low-word fields are: bit 16 to out_mask[n] (1 = masked), bit 15 to out_level[n] (1 = level), bit 13 to out_act_low[n] (1 = active low), bit 11 to out_logical[n] (1 = logical), and bits 10:8 to out_dlv[3n+2:3n] (7 = external-interrupt pass-through). High-word bits 31:24 drive out_dest[8n+7:8n].
- R9: Some data-port accesses select an unimplemented register: register 0x02, registers 0x04 to 0x0F, or a register at or above 0x10+2*NUM_ENT. These accesses read as 0 and writes to them change no register. A bus access at any offset other than 0x00 or 0x10 reads as 0 and is ignored.
- R10: An entry whose number is above the current maximum entry index reads as 0, and writes to it are ignored, so its outputs do not change.
- R11: A read returns its data on bus_rdata one cycle after the access. bus_rdata holds that value until the next read, and writes and idle cycles do not change it. bus_rdata resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset: 0x00 index port, 0x10 data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| out_mask | output | NUM_ENT | Per-entry mask (1 = masked) |
| out_level | output | NUM_ENT | Per-entry trigger mode (1 = level) |
| out_act_low | output | NUM_ENT | Per-entry polarity (1 = active low) |
| out_logical | output | NUM_ENT | Per-entry destination mode (1 = logical) |
| out_dlv | output | 3*NUM_ENT | Per-entry delivery mode, 3 bits each |
| out_dest | output | 8*NUM_ENT | Per-entry destination ID, 8 bits each |

## Verification
The bench writes all-ones words to the ID, version and boot registers. These writes show which bits each register actually stores, as opposed to bits that read as zero or are locked. It writes distinct entry patterns into the first, a middle and the last entry. Pairing external-interrupt delivery with a destination in one entry, and level, active-low and logical modes in another, catches swapped field positions and off-by-one slot addressing. Reads of holes in the register space, of offsets outside the window and of entries above a locked maximum index must all return zero. They must also leave the outputs as the behavioural model predicts, which catches over-wide decoding. A second write to the maximum index field checks the write-once lock against a simple reload.

// File: rtl/irq_redir_pkg.sv
// Package: shared constants and the routing record for the redirection
// register file. Assumes 32-bit data words and an 8-bit register index.
package irq_redir_pkg;

    localparam int IDX_W      = 8;
    localparam int OFS_INDEX  = 'h00;
    localparam int OFS_DATA   = 'h10;
    localparam int REG_IDENT  = 'h00;
    localparam int REG_VERCAP = 'h01;
    localparam int REG_BOOT   = 'h03;
    localparam int REG_TABLE  = 'h10;

    localparam logic [31:0] ENT_LO_RST = 32'h0001_0000;
    localparam logic [31:0] ENT_HI_RST = 32'h0000_0000;

    typedef struct packed {
        logic       masked;
        logic       level;
        logic       act_low;
        logic       logical;
        logic [2:0] dlv;
        logic [7:0] dest;
    } route_t;

endpackage

// File: rtl/irq_redir_window.sv
// Module: index register and register-number decode for the access window.
// Assumes one bus access per cycle; the index written at offset 0x00 takes
// effect on the following cycle. Entry range is bounded by both the table
// depth and the current maximum entry index.
module irq_redir_window
    import irq_redir_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_ENT = 24,
    localparam int ENT_W  = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic [7:0]        max_idx,
    output logic [IDX_W-1:0]  idx,
    output logic              idx_hit,
    output logic              data_hit,
    output logic              sel_ident,
    output logic              sel_vercap,
    output logic              sel_boot,
    output logic              ent_ok,
    output logic [ENT_W-1:0]  ent_num,
    output logic              ent_hi
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] tbl_off;
    logic             in_table;

    assign idx_hit  = (bus_addr == ADDR_W'(OFS_INDEX));
    assign data_hit = (bus_addr == ADDR_W'(OFS_DATA));

    // Index register: loaded by a write at the index port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bus_en && bus_we && idx_hit) begin
            idx_q <= idx_wdata;
        end
    end

    // Register-number decode into fixed registers and table slots.
    always_comb begin
        sel_ident  = (idx_q == IDX_W'(REG_IDENT));
        sel_vercap = (idx_q == IDX_W'(REG_VERCAP));
        sel_boot   = (idx_q == IDX_W'(REG_BOOT));
        in_table   = (idx_q >= IDX_W'(REG_TABLE));
        tbl_off    = idx_q - IDX_W'(REG_TABLE);
        ent_num    = tbl_off[IDX_W-1:1];
        ent_hi     = tbl_off[0];
        ent_ok     = in_table && ({1'b0, ent_num} <= max_idx)
                     && (int'(ent_num) < NUM_ENT);
    end

    assign idx = idx_q;

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && idx_hit) |=> $stable(idx_q)) // R1
        else $error("index changed without an index-port write");

endmodule

// File: rtl/irq_redir_global.sv
// Module: the fixed registers (identification, version/capacity with a
// write-once maximum entry index, boot delivery select). Assumes the write
// strobes are mutually exclusive and already qualified by the window decode.
module irq_redir_global #(
    parameter int          NUM_ENT = 24,
    parameter logic [7:0]  VERSION = 8'h20,
    localparam logic [7:0] MAX_RST = 8'(NUM_ENT - 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ident,
    input  logic        wr_vercap,
    input  logic        wr_boot,
    input  logic [3:0]  id_wdata,
    input  logic [7:0]  max_wdata,
    input  logic        boot_wdata,
    output logic [31:0] ident_word,
    output logic [31:0] vercap_word,
    output logic [31:0] boot_word,
    output logic [7:0]  max_idx
);

    logic [3:0] id_q;
    logic [7:0] max_q;
    logic       max_locked;
    logic       boot_q;

    // Controller ID: only the stored nibble is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (wr_ident) begin
            id_q <= id_wdata;
        end
    end

    // Maximum entry index: accepts one write, then locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q      <= MAX_RST;
            max_locked <= 1'b0;
        end else if (wr_vercap && !max_locked) begin
            max_q      <= max_wdata;
            max_locked <= 1'b1;
        end
    end

    // Boot delivery select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
        end else if (wr_boot) begin
            boot_q <= boot_wdata;
        end
    end

    assign ident_word  = {4'h0, id_q, 24'h0};
    assign vercap_word = {8'h0, max_q, 8'h0, VERSION};
    assign boot_word   = {31'h0, boot_q};
    assign max_idx     = max_q;

    AST_MAX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        max_locked |=> $stable(max_q)) // R4
        else $error("locked maximum entry index changed");

    AST_ID_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ident |=> $stable(id_q)) // R2
        else $error("controller ID changed without a write");

endmodule

// File: rtl/irq_redir_entry.sv
// Module: one 64-bit redirection entry held as two words, with its routing
// fields decoded to a record. Assumes each half's write strobe is already
// qualified by the window's range check.
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word,
    output route_t      route
);

    logic [31:0] lo_q;
    logic [31:0] hi_q;

    // Entry storage: low and high words, reset to masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= ENT_LO_RST;
            hi_q <= ENT_HI_RST;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end
    end

    // Field decode: fixed bit positions of the entry format.
    always_comb begin
        route.masked  = lo_q[16];
        route.level   = lo_q[15];
        route.act_low = lo_q[13];
        route.logical = lo_q[11];
        route.dlv     = lo_q[10:8];
        route.dest    = hi_q[31:24];
    end

    assign lo_word = lo_q;
    assign hi_word = hi_q;

    AST_ENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable({lo_q, hi_q})) // R10
        else $error("entry changed without a qualified write");

endmodule

// File: rtl/irq_redir_regs.sv
// Module: top of the windowed redirection register file. Joins the window
// decode, the fixed registers and NUM_ENT entries; registers read data.
// Assumes at most one access per cycle and NUM_ENT between 1 and 120.
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int         NUM_ENT = 24,
    parameter int         ADDR_W  = 5,
    parameter logic [7:0] VERSION = 8'h20,
    localparam int        ENT_W   = IDX_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_ENT-1:0]   out_mask,
    output logic [NUM_ENT-1:0]   out_level,
    output logic [NUM_ENT-1:0]   out_act_low,
    output logic [NUM_ENT-1:0]   out_logical,
    output logic [3*NUM_ENT-1:0] out_dlv,
    output logic [8*NUM_ENT-1:0] out_dest
);

    logic [IDX_W-1:0] idx;
    logic             idx_hit, data_hit;
    logic             sel_ident, sel_vercap, sel_boot;
    logic             ent_ok, ent_hi;
    logic [ENT_W-1:0] ent_num;
    logic [7:0]       max_idx;
    logic [31:0]      ident_word, vercap_word, boot_word;
    logic             wr_data, wr_ident, wr_vercap, wr_boot;
    logic [NUM_ENT-1:0] wr_lo, wr_hi;
    logic [31:0]      lo_words [NUM_ENT];
    logic [31:0]      hi_words [NUM_ENT];
    route_t           routes   [NUM_ENT];
    logic [31:0]      rd_val;
    logic [31:0]      rdata_q;

    irq_redir_window #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .idx_wdata  (bus_wdata[IDX_W-1:0]),
        .max_idx    (max_idx),
        .idx        (idx),
        .idx_hit    (idx_hit),
        .data_hit   (data_hit),
        .sel_ident  (sel_ident),
        .sel_vercap (sel_vercap),
        .sel_boot   (sel_boot),
        .ent_ok     (ent_ok),
        .ent_num    (ent_num),
        .ent_hi     (ent_hi)
    );

    assign wr_data   = bus_en && bus_we && data_hit;
    assign wr_ident  = wr_data && sel_ident;
    assign wr_vercap = wr_data && sel_vercap;
    assign wr_boot   = wr_data && sel_boot;

    irq_redir_global #(.NUM_ENT(NUM_ENT), .VERSION(VERSION)) u_global (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ident    (wr_ident),
        .wr_vercap   (wr_vercap),
        .wr_boot     (wr_boot),
        .id_wdata    (bus_wdata[27:24]),
        .max_wdata   (bus_wdata[23:16]),
        .boot_wdata  (bus_wdata[0]),
        .ident_word  (ident_word),
        .vercap_word (vercap_word),
        .boot_word   (boot_word),
        .max_idx     (max_idx)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign wr_lo[g] = wr_data && ent_ok && (ent_num == ENT_W'(g)) && !ent_hi;
        assign wr_hi[g] = wr_data && ent_ok && (ent_num == ENT_W'(g)) && ent_hi;

        irq_redir_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wdata   (bus_wdata),
            .lo_word (lo_words[g]),
            .hi_word (hi_words[g]),
            .route   (routes[g])
        );

        assign out_mask[g]        = routes[g].masked;
        assign out_level[g]       = routes[g].level;
        assign out_act_low[g]     = routes[g].act_low;
        assign out_logical[g]     = routes[g].logical;
        assign out_dlv[3*g +: 3]  = routes[g].dlv;
        assign out_dest[8*g +: 8] = routes[g].dest;
    end

    // Read selection: index port, fixed registers, or one entry word.
    always_comb begin
        rd_val = '0;
        if (idx_hit) begin
            rd_val = {{(32-IDX_W){1'b0}}, idx};
        end else if (data_hit) begin
            if (sel_ident)       rd_val = ident_word;
            else if (sel_vercap) rd_val = vercap_word;
            else if (sel_boot)   rd_val = boot_word;
            else if (ent_ok) begin
                for (int i = 0; i < NUM_ENT; i++) begin
                    if (ent_num == ENT_W'(i)) rd_val = ent_hi ? hi_words[i] : lo_words[i];
                end
            end
        end
    end

    // Registered read data, updated only by a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_en && !bus_we) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ident, wr_vercap, wr_boot, wr_lo, wr_hi})) // R9
        else $error("more than one register written in a cycle");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata)) // R11
        else $error("read data changed without a read");

    AST_OFF_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !idx_hit && !data_hit) |=> (bus_rdata == 32'h0)) // R9
        else $error("read outside the window returned data");

    AST_CLOSED_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && data_hit && !sel_ident && !sel_vercap && !sel_boot && !ent_ok)
        |=> (bus_rdata == 32'h0)) // R10
        else $error("closed register returned data");

endmodule

// File: tb/irq_redir_regs_test.sv
module irq_redir_regs_test;

    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    out_mask, out_level, out_act_low, out_logical;
    logic [3*N-1:0]  out_dlv;
    logic [8*N-1:0]  out_dest;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model state
    int          m_idx;
    int          m_id;
    int          m_max;
    bit          m_locked;
    bit          m_boot;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_rdata;

    irq_redir_regs #(.NUM_ENT(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_mask(out_mask), .out_level(out_level), .out_act_low(out_act_low),
        .out_logical(out_logical), .out_dlv(out_dlv), .out_dest(out_dest)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reg(int r);
        if (r == 0) return {4'h0, 4'(m_id), 24'h0};
        if (r == 1) return {8'h0, 8'(m_max), 8'h0, 8'h20};
        if (r == 3) return {31'h0, m_boot};
        if (r >= 16) begin
            int n = (r - 16) / 2;
            if (n <= m_max && n < N) return (r % 2 == 1) ? m_hi[n] : m_lo[n];
        end
        return 32'h0;
    endfunction

    task automatic m_write(int r, logic [31:0] d);
        if (r == 0) m_id = int'(d[27:24]);
        else if (r == 1) begin
            if (!m_locked) begin m_max = int'(d[23:16]); m_locked = 1; end
        end else if (r == 3) m_boot = d[0];
        else if (r >= 16) begin
            int n = (r - 16) / 2;
            if (n <= m_max && n < N) begin
                if (r % 2 == 1) m_hi[n] = d; else m_lo[n] = d;
            end
        end
    endtask

    task automatic m_reset();
        m_idx = 0; m_id = 0; m_max = N - 1; m_locked = 0; m_boot = 0; m_rdata = 0;
        for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 0; end
    endtask

    // one bus access; model follows at the same edge
    task automatic bus_op(input bit we, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        if (we) begin
            if (a == 5'h00) m_idx = int'(d[7:0]);
            else if (a == 5'h10) m_write(m_idx, d);
        end else begin
            if (a == 5'h00) m_rdata = {24'h0, 8'(m_idx)};
            else if (a == 5'h10) m_rdata = m_reg(m_idx);
            else m_rdata = 0;
        end
        bus_en = 0; bus_we = 0;
    endtask

    task automatic wr_reg(input int r, input logic [31:0] d);
        bus_op(1, 5'h00, 32'(r));
        bus_op(1, 5'h10, d);
    endtask

    task automatic rd_reg(input int r, output logic [31:0] v);
        bus_op(1, 5'h00, 32'(r));
        bus_op(0, 5'h10, 32'h0);
        @(negedge clk);
        v = bus_rdata;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 rdata", bus_rdata, m_rdata);
            for (int i = 0; i < N; i++) begin
                chk("R8 route",
                    {17'h0, out_mask[i], out_level[i], out_act_low[i], out_logical[i],
                     out_dlv[3*i +: 3], out_dest[8*i +: 8]},
                    {17'h0, m_lo[i][16], m_lo[i][15], m_lo[i][13], m_lo[i][11],
                     m_lo[i][10:8], m_hi[i][31:24]});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        chk("R11 reset rdata", bus_rdata, 32'h0);
        chk("R7 reset mask", 32'(out_mask), 32'(24'hFF_FFFF));
        bus_op(0, 5'h00, 0); @(negedge clk);
        chk("R1 reset index", bus_rdata, 32'h0);
        rd_reg(0, v);  chk("R2 reset id", v, 32'h0);
        rd_reg(1, v);  chk("R3 version/max", v, 32'h0017_0020);
        rd_reg(3, v);  chk("R5 reset boot", v, 32'h0);
        rd_reg(16, v); chk("R7 reset low", v, 32'h0001_0000);
        rd_reg(17, v); chk("R7 reset high", v, 32'h0);

        // index readback
        bus_op(1, 5'h00, 32'hABCD_EF37);
        bus_op(0, 5'h00, 0); @(negedge clk);
        chk("R1 index readback", bus_rdata, 32'h37);

        // ID nibble
        wr_reg(0, 32'hFFFF_FFFF);
        rd_reg(0, v); chk("R2 id nibble", v, 32'h0F00_0000);
        wr_reg(0, 32'h0500_0000);
        rd_reg(0, v); chk("R2 id rewrite", v, 32'h0500_0000);

        // boot select
        wr_reg(3, 32'hFFFF_FFFF);
        rd_reg(3, v); chk("R5 boot set", v, 32'h1);
        wr_reg(3, 32'h0);
        rd_reg(3, v); chk("R5 boot clear", v, 32'h0);

        // entry patterns: first, middle, last
        wr_reg(16, 32'h0000_0700);
        wr_reg(17, 32'h0500_0000);
        rd_reg(16, v); chk("R6 entry0 low", v, 32'h0000_0700);
        rd_reg(17, v); chk("R6 entry0 high", v, 32'h0500_0000);
        chk("R8 entry0 dlv", 32'(out_dlv[2:0]), 32'h7);
        chk("R8 entry0 dest", 32'(out_dest[7:0]), 32'h05);
        chk("R8 entry0 unmasked", 32'(out_mask[0]), 32'h0);
        wr_reg(16 + 2*5, 32'h0001_A8C3);
        wr_reg(17 + 2*5, 32'hA500_1234);
        rd_reg(16 + 2*5, v); chk("R6 entry5 low", v, 32'h0001_A8C3);
        rd_reg(17 + 2*5, v); chk("R6 entry5 high", v, 32'hA500_1234);
        chk("R8 entry5 flags", {28'h0, out_mask[5], out_level[5], out_act_low[5], out_logical[5]}, 32'hF);
        wr_reg(16 + 2*23, 32'h0000_2100);
        wr_reg(17 + 2*23, 32'hFF00_0000);
        rd_reg(16 + 2*23, v); chk("R6 entry23 low", v, 32'h0000_2100);
        chk("R8 entry23 dest", 32'(out_dest[8*23 +: 8]), 32'hFF);
        chk("R8 entry23 pol", 32'(out_act_low[23]), 32'h1);

        // holes and off-window accesses
        wr_reg(2, 32'hDEAD_BEEF);
        rd_reg(2, v); chk("R9 reg2", v, 32'h0);
        wr_reg(10, 32'hDEAD_BEEF);
        rd_reg(10, v); chk("R9 reg0A", v, 32'h0);
        wr_reg(16 + 2*N, 32'hDEAD_BEEF);
        rd_reg(16 + 2*N, v); chk("R9 beyond table", v, 32'h0);
        bus_op(1, 5'h00, 32'h11);
        bus_op(1, 5'h08, 32'h22);
        bus_op(0, 5'h04, 0); @(negedge clk);
        chk("R9 off-window read", bus_rdata, 32'h0);
        bus_op(0, 5'h00, 0); @(negedge clk);
        chk("R9 off-window write ignored", bus_rdata, 32'h11);

        // read data hold
        rd_reg(0, v);
        wr_reg(3, 32'h1);
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 32'h0500_0000);

        // write-once maximum index
        wr_reg(1, 32'h000F_00FF);
        rd_reg(1, v); chk("R4 first write", v, 32'h000F_0020);
        wr_reg(1, 32'h0017_0000);
        rd_reg(1, v); chk("R4 locked", v, 32'h000F_0020);
        rd_reg(16 + 2*23, v); chk("R10 closed entry23", v, 32'h0);
        wr_reg(16 + 2*16, 32'h0000_0000);
        chk("R10 entry16 still masked", 32'(out_mask[16]), 32'h1);
        rd_reg(16 + 2*16, v); chk("R10 closed entry16", v, 32'h0);
        wr_reg(16 + 2*15, 32'h0000_8000);
        rd_reg(16 + 2*15, v); chk("R10 entry15 open", v, 32'h0000_8000);
        chk("R8 entry15 level", 32'(out_level[15]), 32'h1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule